// File: doc/BRIEF.md
# Flash Write-Status Polling Responder

This block stands in for the status-read side of a parallel NOR flash while one of its internal program or erase runs is in progress. A host issues single-cycle commands (program a byte, erase a set of sectors, suspend an erase, resume it) on a synchronous command strobe. It then polls with a read strobe. While an operation is running, a read whose address qualifies returns a polling byte rather than the stored data. Bit 7 of that byte carries the status and the lower bits read as zero. A program returns the inverse of the datum's top bit. An erase returns 0, and a suspended erase returns 1. Once the operation ends, the same address returns the stored byte.

Sector protection flags come in on an input and are sampled when a command is accepted. A program aimed at a protected sector, or an erase whose selected sectors are all protected, still shows a busy window. That window is shorter or longer depending on the operation, and its length is derived from the clock frequency parameter. When it closes, reads return the unchanged data. The array is a small register file so that the status behaviour can be exercised end to end.

Top module: `fpr_top`

## Requirements
- R1: After reset every byte of the array reads 8'hFF, no operation is running and `rd_data` is 0.
- R2: `rd_data` is registered: it reflects the read issued with `rd_en` at one rising edge just after that edge, and holds its value on edges without `rd_en`.
- R3: A program command (`cmd_op`=1, byte at `cmd_addr`, datum `cmd_data`) keeps the device busy for PROG_CYC edges after the command edge; reads at the program address in that time return {~datum[7], 7'b0}, while reads elsewhere return stored data.
- R4: A completed program stores (old byte AND datum) at the program address.
- R5: A program whose sector is protected (sector = `cmd_addr[5:4]`, protected when `sect_lock[sector]` is 1) shows the R3 status for CLK_MHZ edges (about 1 µs) and leaves the array unchanged.
- R6: An erase command (`cmd_op`=2, `cmd_sect_sel` bit i selects sector i) with at least one unprotected selected sector runs for ERASE_CYC edges. Reads in any selected sector return 8'h00, and reads in other sectors return stored data. At the end, the unprotected selected sectors hold 8'hFF and the protected selected sectors are unchanged.
- R7: An erase whose selected sectors are all protected returns 8'h00 in those sectors for 100*CLK_MHZ edges (about 100 µs), then array reads resume with no data changed.
- R8: A suspend command (`cmd_op`=3) during a running erase freezes its remaining time. While suspended, reads in selected sectors return 8'h80. A resume command (`cmd_op`=4) continues the erase for exactly the remaining edges.
- R9: While an erase is suspended, a program outside the selected sectors runs with the R3/R4 behaviour and returns to the suspended state. A program inside a selected sector is ignored.
- R10: Commands that are not listed above for the current state are ignored, including any command while a program is running. An erase with an empty sector selection is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | 1 program, 2 erase, 3 suspend, 4 resume |
| cmd_addr | input | ADDR_W | Program byte address |
| cmd_data | input | DATA_W | Program datum |
| cmd_sect_sel | input | 2**SECT_W | Erase sector selection, one bit per sector |
| sect_lock | input | 2**SECT_W | Sector protection flags |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read result: array byte or polling byte |

## Verification
A command takes effect at the edge where it is strobed. A read strobed at the following edge already sees the status. The byte read is due just after the edge that sampled its `rd_en`. The bench therefore drives every strobe at a falling edge and samples `rd_data` at the next falling edge. Each command and each read uses exactly one rising edge. Busy windows are measured by polling one address every cycle and counting the reads that return the status byte. The expected count is PROG_CYC, ERASE_CYC, CLK_MHZ or 100*CLK_MHZ, minus any edges already spent inside the window by earlier reads or ignored commands. The first non-status byte is then compared with the expected array content.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_SUSP   = 3'd3,
        OP_RESUME = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_ESUSP = 3'd3,
        ST_SPROG = 3'd4
    } st_e;

endpackage

// File: rtl/fpr_sect_dec.sv
module fpr_sect_dec #(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 2,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NSECT-1:0]  sect_oh
);

    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        assign sect_oh[g] = (addr[ADDR_W-1 -: SECT_W] == SECT_W'(g));
    end

endmodule

// File: rtl/fpr_array.sv
module fpr_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int SECT_W = 2,
    localparam int NSECT     = 1 << SECT_W,
    localparam int DEPTH     = 1 << ADDR_W,
    localparam int SECT_SIZE = DEPTH / NSECT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_commit,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_commit,
    input  logic [NSECT-1:0]  erase_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_byte
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } arr_t;

    arr_t arr_d, arr_q;
    logic [DEPTH-1:0][DATA_W-1:0] byte_nxt;

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        localparam int SEC = g / SECT_SIZE;
        logic erase_hit;
        logic prog_hit;
        assign erase_hit = erase_commit && erase_mask[SEC];
        assign prog_hit  = prog_commit && (prog_addr == ADDR_W'(g));
        assign byte_nxt[g] = erase_hit ? {DATA_W{1'b1}} :
                             prog_hit  ? (arr_q.mem[g] & prog_data) :
                                         arr_q.mem[g];
    end

    always_comb begin
        arr_d     = arr_q;
        arr_d.mem = byte_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_q.mem <= '1;
        end else begin
            arr_q <= arr_d;
        end
    end

    assign rd_byte = arr_q.mem[rd_addr];

endmodule

// File: rtl/fpr_ctrl.sv
module fpr_ctrl
    import fpr_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int SECT_W    = 2,
    parameter int CLK_MHZ   = 4,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40,
    localparam int NSECT      = 1 << SECT_W,
    localparam int LPROG_CYC  = CLK_MHZ,
    localparam int LERASE_CYC = 100 * CLK_MHZ,
    localparam int MAX_A      = (PROG_CYC > LPROG_CYC) ? PROG_CYC : LPROG_CYC,
    localparam int MAX_B      = (ERASE_CYC > LERASE_CYC) ? ERASE_CYC : LERASE_CYC,
    localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B,
    localparam int CW         = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [NSECT-1:0]  cmd_sect_sel,
    input  logic [NSECT-1:0]  cmd_sect_oh,
    input  logic [NSECT-1:0]  sect_lock,
    output st_e               st,
    output logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pdata,
    output logic [NSECT-1:0]  esel,
    output logic [CW-1:0]     ecnt,
    output logic              prog_commit,
    output logic              erase_commit,
    output logic [NSECT-1:0]  erase_mask
);

    typedef struct packed {
        st_e               st;
        logic [CW-1:0]     pcnt;
        logic [CW-1:0]     ecnt;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
        logic              pfake;
        logic [NSECT-1:0]  esel;
        logic [NSECT-1:0]  eeff;
        logic              efake;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic is_prog, is_erase, is_susp, is_resume;
    logic prog_locked, prog_in_esel;
    logic [NSECT-1:0] eff_sel;

    assign is_prog   = cmd_valid && (cmd_op == OP_PROG);
    assign is_erase  = cmd_valid && (cmd_op == OP_ERASE);
    assign is_susp   = cmd_valid && (cmd_op == OP_SUSP);
    assign is_resume = cmd_valid && (cmd_op == OP_RESUME);

    assign prog_locked  = |(cmd_sect_oh & sect_lock);
    assign prog_in_esel = |(cmd_sect_oh & ctl_q.esel);
    assign eff_sel      = cmd_sect_sel & ~sect_lock;

    always_comb begin
        ctl_d        = ctl_q;
        prog_commit  = 1'b0;
        erase_commit = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (is_prog) begin
                    ctl_d.st    = ST_PROG;
                    ctl_d.paddr = cmd_addr;
                    ctl_d.pdata = cmd_data;
                    ctl_d.pfake = prog_locked;
                    ctl_d.pcnt  = prog_locked ? CW'(LPROG_CYC) : CW'(PROG_CYC);
                end else if (is_erase && (|cmd_sect_sel)) begin
                    ctl_d.st    = ST_ERASE;
                    ctl_d.esel  = cmd_sect_sel;
                    ctl_d.eeff  = eff_sel;
                    ctl_d.efake = ~|eff_sel;
                    ctl_d.ecnt  = (~|eff_sel) ? CW'(LERASE_CYC) : CW'(ERASE_CYC);
                end
            end
            ST_PROG, ST_SPROG: begin
                if (ctl_q.pcnt == CW'(1)) begin
                    prog_commit = !ctl_q.pfake;
                    ctl_d.st    = (ctl_q.st == ST_SPROG) ? ST_ESUSP : ST_IDLE;
                end else begin
                    ctl_d.pcnt = ctl_q.pcnt - CW'(1);
                end
            end
            ST_ERASE: begin
                if (is_susp && !ctl_q.efake) begin
                    ctl_d.st = ST_ESUSP;
                end else if (ctl_q.ecnt == CW'(1)) begin
                    erase_commit = !ctl_q.efake;
                    ctl_d.st     = ST_IDLE;
                end else begin
                    ctl_d.ecnt = ctl_q.ecnt - CW'(1);
                end
            end
            ST_ESUSP: begin
                if (is_resume) begin
                    ctl_d.st = ST_ERASE;
                end else if (is_prog && !prog_in_esel) begin
                    ctl_d.st    = ST_SPROG;
                    ctl_d.paddr = cmd_addr;
                    ctl_d.pdata = cmd_data;
                    ctl_d.pfake = prog_locked;
                    ctl_d.pcnt  = prog_locked ? CW'(LPROG_CYC) : CW'(PROG_CYC);
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign st         = ctl_q.st;
    assign paddr      = ctl_q.paddr;
    assign pdata      = ctl_q.pdata;
    assign esel       = ctl_q.esel;
    assign ecnt       = ctl_q.ecnt;
    assign erase_mask = ctl_q.eeff;

endmodule

// File: rtl/fpr_top.sv
module fpr_top
    import fpr_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int SECT_W    = 2,
    parameter int CLK_MHZ   = 4,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40,
    localparam int NSECT      = 1 << SECT_W,
    localparam int LPROG_CYC  = CLK_MHZ,
    localparam int LERASE_CYC = 100 * CLK_MHZ,
    localparam int MAX_A      = (PROG_CYC > LPROG_CYC) ? PROG_CYC : LPROG_CYC,
    localparam int MAX_B      = (ERASE_CYC > LERASE_CYC) ? ERASE_CYC : LERASE_CYC,
    localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B,
    localparam int CW         = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [NSECT-1:0]  cmd_sect_sel,
    input  logic [NSECT-1:0]  sect_lock,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
    } out_t;

    out_t out_d, out_q;

    st_e               ctl_st;
    logic [ADDR_W-1:0] ctl_paddr;
    logic [DATA_W-1:0] ctl_pdata;
    logic [NSECT-1:0]  ctl_esel;
    logic [CW-1:0]     ctl_ecnt;
    logic              prog_commit, erase_commit;
    logic [NSECT-1:0]  erase_mask;
    logic [NSECT-1:0]  cmd_sect_oh, rd_sect_oh;
    logic [DATA_W-1:0] arr_byte;
    logic              prog_busy, erase_run, erase_held, rd_in_esel;

    fpr_sect_dec #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_cmd_dec (
        .addr    (cmd_addr),
        .sect_oh (cmd_sect_oh)
    );

    fpr_sect_dec #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_rd_dec (
        .addr    (rd_addr),
        .sect_oh (rd_sect_oh)
    );

    fpr_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
        .CLK_MHZ(CLK_MHZ), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_addr     (cmd_addr),
        .cmd_data     (cmd_data),
        .cmd_sect_sel (cmd_sect_sel),
        .cmd_sect_oh  (cmd_sect_oh),
        .sect_lock    (sect_lock),
        .st           (ctl_st),
        .paddr        (ctl_paddr),
        .pdata        (ctl_pdata),
        .esel         (ctl_esel),
        .ecnt         (ctl_ecnt),
        .prog_commit  (prog_commit),
        .erase_commit (erase_commit),
        .erase_mask   (erase_mask)
    );

    fpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) i_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_commit  (prog_commit),
        .prog_addr    (ctl_paddr),
        .prog_data    (ctl_pdata),
        .erase_commit (erase_commit),
        .erase_mask   (erase_mask),
        .rd_addr      (rd_addr),
        .rd_byte      (arr_byte)
    );

    assign prog_busy  = (ctl_st == ST_PROG) || (ctl_st == ST_SPROG);
    assign erase_run  = (ctl_st == ST_ERASE);
    assign erase_held = (ctl_st == ST_ESUSP) || (ctl_st == ST_SPROG);
    assign rd_in_esel = |(rd_sect_oh & ctl_esel);

    always_comb begin
        out_d = out_q;
        if (rd_en) begin
            if (prog_busy && (rd_addr == ctl_paddr)) begin
                out_d.rd_data = {~ctl_pdata[DATA_W-1], {(DATA_W-1){1'b0}}};
            end else if (erase_run && rd_in_esel) begin
                out_d.rd_data = '0;
            end else if (erase_held && rd_in_esel) begin
                out_d.rd_data = {1'b1, {(DATA_W-1){1'b0}}};
            end else begin
                out_d.rd_data = arr_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data = out_q.rd_data;

endmodule

// File: rtl/fpr_chk.sv
module fpr_chk
    import fpr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int NSECT  = 4,
    parameter int CW     = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [NSECT-1:0]  rd_sect_oh,
    input st_e               st,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pdata,
    input logic [NSECT-1:0]  esel,
    input logic [CW-1:0]     ecnt
);

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R3
    prog_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (st == ST_PROG || st == ST_SPROG) && rd_addr == paddr)
        |=> (rd_data[DATA_W-2:0] == '0) && (rd_data[DATA_W-1] != $past(pdata[DATA_W-1])));

    // R6
    erase_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_ERASE && |(rd_sect_oh & esel)) |=> (rd_data == '0));

    // R8
    susp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ESUSP || st == ST_SPROG) |=> $stable(ecnt));

    // R8
    susp_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_ESUSP && |(rd_sect_oh & esel))
        |=> (rd_data == {1'b1, {(DATA_W-1){1'b0}}}));

    // R10
    prog_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |=> (st == ST_PROG || st == ST_IDLE));

endmodule

bind fpr_top fpr_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSECT(NSECT), .CW(CW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .rd_sect_oh (rd_sect_oh),
    .st         (ctl_st),
    .paddr      (ctl_paddr),
    .pdata      (ctl_pdata),
    .esel       (ctl_esel),
    .ecnt       (ctl_ecnt)
);

// File: tb/test_fpr_top.sv
module test_fpr_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int NS = 4;
    localparam int CLK_MHZ = 4;
    localparam int PROG_CYC = 8;
    localparam int ERASE_CYC = 40;
    localparam int LPROG = CLK_MHZ;
    localparam int LERASE = 100 * CLK_MHZ;

    localparam logic [2:0] OPC_PROG = 3'd1, OPC_ERASE = 3'd2, OPC_SUSP = 3'd3, OPC_RES = 3'd4;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [15:0]   cnt;
        logic [DW-1:0] fin;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{6'h05, 8'h3C, 16'd8, 8'h3C},
        '{6'h12, 8'hA5, 16'd8, 8'hA5},
        '{6'h05, 8'hF0, 16'd8, 8'h30},
        '{6'h31, 8'h00, 16'd4, 8'hFF},
        '{6'h2A, 8'h81, 16'd8, 8'h81},
        '{6'h3F, 8'h55, 16'd4, 8'hFF},
        '{6'h07, 8'h7F, 16'd8, 8'h7F}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [NS-1:0] cmd_sect_sel = '0;
    logic [NS-1:0] sect_lock = 4'b1000;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpr_top #(
        .ADDR_W(AW), .DATA_W(DW), .SECT_W(2),
        .CLK_MHZ(CLK_MHZ), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) i_fpr_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sect_sel(cmd_sect_sel),
        .sect_lock(sect_lock), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [NS-1:0] sel);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_sect_sel = sel;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic poll(input logic [AW-1:0] a, input logic [DW-1:0] status,
                        output int n, output logic [DW-1:0] last);
        logic [DW-1:0] v;
        n = 0;
        rd(a, v);
        while (v == status && n < 2000) begin
            n++;
            rd(a, v);
        end
        last = v;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_data after reset", rd_data, 0);
        rd(6'h00, v); check("R1 erased byte 0x00", v, 8'hFF);
        rd(6'h3F, v); check("R1 erased byte 0x3F", v, 8'hFF);

        // R2 hold without rd_en
        rd_addr = 6'h10;
        repeat (3) @(negedge clk);
        check("R2 hold without rd_en", rd_data, 8'hFF);

        // R3 R4 R5 table of program vectors
        for (int i = 0; i < NVEC; i++) begin
            issue(OPC_PROG, VEC[i].addr, VEC[i].data, '0);
            poll(VEC[i].addr, {~VEC[i].data[7], 7'b0}, n, v);
            if (VEC[i].cnt == 16'(LPROG)) begin
                check("R5 locked program busy length", n, LPROG);
                check("R5 locked program leaves data", v, VEC[i].fin);
            end else begin
                check("R3 program busy length", n, PROG_CYC);
                check("R4 program result", v, VEC[i].fin);
            end
        end

        // R3 other addresses read array during program
        issue(OPC_PROG, 6'h08, 8'h11, '0);
        rd(6'h12, v); check("R3 other address reads array", v, 8'hA5);
        poll(6'h08, 8'h80, n, v);
        check("R3 remaining busy length", n, PROG_CYC - 1);
        check("R4 program 0x08", v, 8'h11);

        // R10 erase during program ignored
        issue(OPC_PROG, 6'h09, 8'h22, '0);
        rd(6'h09, v); check("R3 status at program address", v, 8'h80);
        issue(OPC_ERASE, '0, '0, 4'b0001);
        poll(6'h09, 8'h80, n, v);
        check("R10 program length unaffected", n, PROG_CYC - 2);
        check("R4 program 0x09", v, 8'h22);
        rd(6'h05, v); check("R10 erase while busy ignored", v, 8'h30);

        // R10 empty erase selection
        issue(OPC_ERASE, '0, '0, 4'b0000);
        rd(6'h05, v); check("R10 empty erase ignored", v, 8'h30);

        // R6 R8 R9 erase with suspend
        sect_lock = 4'b0100;
        issue(OPC_ERASE, '0, '0, 4'b0101);
        rd(6'h05, v); check("R6 selected sector status", v, 8'h00);
        rd(6'h2A, v); check("R6 locked selected sector status", v, 8'h00);
        rd(6'h12, v); check("R6 unselected sector array", v, 8'hA5);
        issue(OPC_SUSP, '0, '0, '0);
        rd(6'h05, v); check("R8 suspended status", v, 8'h80);
        rd(6'h12, v); check("R8 unselected during suspend", v, 8'hA5);
        repeat (5) @(negedge clk);
        issue(OPC_PROG, 6'h06, 8'h80, '0);
        rd(6'h06, v); check("R9 program in selected sector ignored", v, 8'h80);
        issue(OPC_PROG, 6'h13, 8'h5A, '0);
        poll(6'h13, 8'h80, n, v);
        check("R9 suspended program length", n, PROG_CYC);
        check("R9 suspended program result", v, 8'h5A);
        rd(6'h05, v); check("R9 back to suspend", v, 8'h80);
        issue(OPC_RES, '0, '0, '0);
        poll(6'h05, 8'h00, n, v);
        check("R8 remaining erase length", n, ERASE_CYC - 3);
        check("R6 erased byte", v, 8'hFF);
        rd(6'h07, v); check("R6 erased 0x07", v, 8'hFF);
        rd(6'h2A, v); check("R6 locked sector kept", v, 8'h81);
        rd(6'h06, v); check("R9 ignored program left no data", v, 8'hFF);
        rd(6'h13, v); check("R6 unselected sector kept", v, 8'h5A);

        // R7 all selected sectors locked
        issue(OPC_ERASE, '0, '0, 4'b0100);
        poll(6'h2A, 8'h00, n, v);
        check("R7 locked erase length", n, LERASE);
        check("R7 locked erase leaves data", v, 8'h81);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule